// File: doc/BRIEF.md
# Debug Address Space Decoder

The decoder accepts one debug access at a time: a 32-bit address and a byte count. It splits the address into a segment code and an offset and decides where the access goes. Three codes select direct physical regions: unified, instruction and data. For these the decoder adds a region base to the offset. It clips the count so that the transfer stops at the next segment boundary. Two codes select logical regions. For these the offset and count go out on a request/response port to an external data-side or instruction-side translator, and the physical address and granted count it returns are passed through. Every other code is refused with a count of zero.

A configuration bit selects an alternate segment numbering. While it is set, a fixed set of codes is renumbered before decoding, so that older debug software can reach the same regions under the old numbers. The bit is written through a control port. It is sampled when a request is accepted, so a write never changes a request that is already in flight.

The control is a five-state machine:
- `ST_IDLE` accepts a request (transition *accept*).
- `ST_ROUTE` decodes the latched request. It goes to `ST_DONE` for a direct region or a refused code (*resolve*), to `ST_WAIT_DX` for the data translator (*to_dx*), or to `ST_WAIT_IX` for the instruction translator (*to_ix*).
- Each wait state goes to `ST_DONE` when its translator responds (*dx_back*, *ix_back*).
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE` (*retire*).

Top module: `dbg_addr_router`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, neither translator request is raised, and the alternate numbering is off, so code 0x00 decodes as the unified region.
- R2: The segment code is `req_addr[31:24]` and the offset is `req_addr[23:0]`; all 24 offset bits reach the physical address.
- R3: With the alternate numbering on, codes are renumbered before decoding: 0x00 becomes 0x10, 0x01 becomes 0x11, 0x10 becomes 0x02, 0x11 becomes 0x01 and 0x12 becomes 0x00. All other codes are unchanged.
- R4: Code 0x00 gives `UNIF_BASE`+offset, code 0x01 gives `INSN_BASE`+offset, and code 0x02 gives `DATA_BASE`+offset.
- R5: For the three direct regions, if count > `SEG_BYTES` − (offset mod `SEG_BYTES`), the granted count is that difference; otherwise it is the requested count. `SEG_BYTES` is a power of two.
- R6: Code 0x10 raises `dx_req_valid` with the offset and the count and holds them until `dx_rsp_valid`. The response phys and count become the result unchanged.
- R7: Code 0x11 does the same on the `ix_` port.
- R8: Any other code gives a granted count of 0 and a physical address of 0.
- R9: `req_ready` is 1 only in the idle state. Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and `req_valid` is ignored while busy.
- R10: A cycle with `cfg_wr_en` high loads `cfg_alt_num` into the numbering bit; clearing it restores the default decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the numbering bit |
| cfg_alt_num | input | 1 | New value of the alternate-numbering bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder idle, request taken this cycle |
| req_addr | input | 32 | Debug address |
| req_count | input | 16 | Requested byte count |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_phys | output | 32 | Physical address |
| rsp_count | output | 16 | Granted byte count |
| dx_req_valid | output | 1 | Data translator request |
| dx_req_offset | output | 24 | Offset sent to the data translator |
| dx_req_count | output | 16 | Count sent to the data translator |
| dx_rsp_valid | input | 1 | Data translator response |
| dx_rsp_phys | input | 32 | Data translator physical address |
| dx_rsp_count | input | 16 | Data translator granted count |
| ix_req_valid | output | 1 | Instruction translator request |
| ix_req_offset | output | 24 | Offset sent to the instruction translator |
| ix_req_count | output | 16 | Count sent to the instruction translator |
| ix_rsp_valid | input | 1 | Instruction translator response |
| ix_rsp_phys | input | 32 | Instruction translator physical address |
| ix_rsp_count | input | 16 | Instruction translator granted count |

## Verification
The hardest situation to reach is a request arriving while the decoder waits on a translator, since the decoder hides that window behind `req_ready`. The bench's translator models answer only after several cycles. During that wait the bench raises `req_valid` with a different address and then drops it before the decoder returns to idle, and the scoreboard fails on any extra response. The renumbering is covered by switching the mode on and sending every renumbered code plus two codes that must pass through unchanged. The bench then switches the mode off again and repeats a logical code.

// File: rtl/dbg_addr_pkg.sv
package dbg_addr_pkg;

    typedef enum logic [2:0] {
        RGN_UNIF,
        RGN_INSN,
        RGN_DATA,
        RGN_DXLT,
        RGN_IXLT,
        RGN_NONE
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_WAIT_DX,
        ST_WAIT_IX,
        ST_DONE
    } state_e;

    function automatic logic is_direct(input region_e r);
        return (r == RGN_UNIF) || (r == RGN_INSN) || (r == RGN_DATA);
    endfunction

endpackage

// File: rtl/dbg_addr_seg_remap.sv
module dbg_addr_seg_remap #(
    parameter int CODE_W = 8
) (
    input  logic              alt_num,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out
);
    // Alternate numbering: a fixed renumbering applied ahead of the decode.
    always_comb begin
        code_out = code_in;
        if (alt_num) begin
            unique case (code_in)
                CODE_W'(8'h00): code_out = CODE_W'(8'h10);
                CODE_W'(8'h01): code_out = CODE_W'(8'h11);
                CODE_W'(8'h10): code_out = CODE_W'(8'h02);
                CODE_W'(8'h11): code_out = CODE_W'(8'h01);
                CODE_W'(8'h12): code_out = CODE_W'(8'h00);
                default:        code_out = code_in;
            endcase
        end
    end
endmodule

// File: rtl/dbg_addr_seg_classify.sv
module dbg_addr_seg_classify
    import dbg_addr_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output region_e           region
);
    always_comb begin
        unique case (code)
            CODE_W'(8'h00): region = RGN_UNIF;
            CODE_W'(8'h01): region = RGN_INSN;
            CODE_W'(8'h02): region = RGN_DATA;
            CODE_W'(8'h10): region = RGN_DXLT;
            CODE_W'(8'h11): region = RGN_IXLT;
            default:        region = RGN_NONE;
        endcase
    end
endmodule

// File: rtl/dbg_addr_direct.sv
module dbg_addr_direct
    import dbg_addr_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              OFF_W     = 24,
    parameter int              CNT_W     = 16,
    parameter int              SEG_BYTES = 32'h0002_0000,
    parameter logic [ADDR_W-1:0] UNIF_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] INSN_BASE = 32'h5000_0000,
    parameter logic [ADDR_W-1:0] DATA_BASE = 32'h6000_0000
) (
    input  region_e           region,
    input  logic [OFF_W-1:0]  offset,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] phys,
    output logic [CNT_W-1:0]  count_out
);
    localparam int SEG_LG = $clog2(SEG_BYTES);
    localparam int ROOM_W = SEG_LG + 1;
    localparam int CMP_W  = (ROOM_W > CNT_W) ? ROOM_W : CNT_W;

    generate
        if ((SEG_BYTES & (SEG_BYTES - 1)) != 0) begin : g_seg_not_pow2
            $error("SEG_BYTES must be a power of two");
        end
        if (SEG_LG > OFF_W) begin : g_seg_too_big
            $error("SEG_BYTES must not exceed the offset range");
        end
    endgenerate

    logic [SEG_LG-1:0] off_in_seg;
    logic [CMP_W-1:0]  room;
    logic [CMP_W-1:0]  cnt_wide;
    logic [ADDR_W-1:0] base;

    always_comb begin
        off_in_seg = offset[SEG_LG-1:0];
        room       = CMP_W'(SEG_BYTES) - CMP_W'(off_in_seg);
        cnt_wide   = CMP_W'(count);
        // Clipped value is below count, so it always fits CNT_W.
        count_out  = (cnt_wide > room) ? CNT_W'(room) : count;
    end

    always_comb begin
        unique case (region)
            RGN_INSN: base = INSN_BASE;
            RGN_DATA: base = DATA_BASE;
            default:  base = UNIF_BASE;
        endcase
        phys = base + ADDR_W'(offset);
    end
endmodule

// File: rtl/dbg_addr_router.sv
module dbg_addr_router
    import dbg_addr_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                OFF_W     = 24,
    parameter int                CNT_W     = 16,
    parameter int                SEG_BYTES = 32'h0002_0000,
    parameter logic [ADDR_W-1:0] UNIF_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] INSN_BASE = 32'h5000_0000,
    parameter logic [ADDR_W-1:0] DATA_BASE = 32'h6000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_alt_num,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic [CNT_W-1:0]  rsp_count,
    output logic              dx_req_valid,
    output logic [OFF_W-1:0]  dx_req_offset,
    output logic [CNT_W-1:0]  dx_req_count,
    input  logic              dx_rsp_valid,
    input  logic [ADDR_W-1:0] dx_rsp_phys,
    input  logic [CNT_W-1:0]  dx_rsp_count,
    output logic              ix_req_valid,
    output logic [OFF_W-1:0]  ix_req_offset,
    output logic [CNT_W-1:0]  ix_req_count,
    input  logic              ix_rsp_valid,
    input  logic [ADDR_W-1:0] ix_rsp_phys,
    input  logic [CNT_W-1:0]  ix_rsp_count
);
    localparam int CODE_W = ADDR_W - OFF_W;

    state_e            state_q, state_d;
    logic              alt_num_q;
    region_e           region_c, lat_region;
    logic [CODE_W-1:0] code_mapped;
    logic [OFF_W-1:0]  lat_off;
    logic [CNT_W-1:0]  lat_cnt;
    logic [ADDR_W-1:0] dir_phys, phys_q;
    logic [CNT_W-1:0]  dir_cnt, cnt_q;
    logic              accept;

    // Decode at the accept edge: numbering bit is sampled here (R3, R10).
    dbg_addr_seg_remap #(.CODE_W(CODE_W)) u_remap (
        .alt_num  (alt_num_q),
        .code_in  (req_addr[ADDR_W-1:OFF_W]),
        .code_out (code_mapped)
    );

    dbg_addr_seg_classify #(.CODE_W(CODE_W)) u_classify (
        .code   (code_mapped),
        .region (region_c)
    );

    dbg_addr_direct #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .CNT_W     (CNT_W),
        .SEG_BYTES (SEG_BYTES),
        .UNIF_BASE (UNIF_BASE),
        .INSN_BASE (INSN_BASE),
        .DATA_BASE (DATA_BASE)
    ) u_direct (
        .region    (lat_region),
        .offset    (lat_off),
        .count     (lat_cnt),
        .phys      (dir_phys),
        .count_out (dir_cnt)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ROUTE;
            ST_ROUTE: begin
                unique case (lat_region)
                    RGN_DXLT: state_d = ST_WAIT_DX;
                    RGN_IXLT: state_d = ST_WAIT_IX;
                    default:  state_d = ST_DONE;
                endcase
            end
            ST_WAIT_DX: if (dx_rsp_valid) state_d = ST_DONE;
            ST_WAIT_IX: if (ix_rsp_valid) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = (state_q == ST_DONE);
        dx_req_valid  = (state_q == ST_WAIT_DX);
        ix_req_valid  = (state_q == ST_WAIT_IX);
        dx_req_offset = lat_off;
        dx_req_count  = lat_cnt;
        ix_req_offset = lat_off;
        ix_req_count  = lat_cnt;
        rsp_phys      = phys_q;
        rsp_count     = cnt_q;
    end

    // Numbering bit, written through the control port.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         alt_num_q <= 1'b0;
        else if (cfg_wr_en) alt_num_q <= cfg_alt_num;
    end

    // Request latch and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_region <= RGN_NONE;
            lat_off    <= '0;
            lat_cnt    <= '0;
            phys_q     <= '0;
            cnt_q      <= '0;
        end else begin
            if (accept) begin
                lat_region <= region_c;
                lat_off    <= req_addr[OFF_W-1:0];
                lat_cnt    <= req_count;
            end
            if (state_q == ST_ROUTE) begin
                if (is_direct(lat_region)) begin
                    phys_q <= dir_phys;
                    cnt_q  <= dir_cnt;
                end else begin
                    phys_q <= '0;
                    cnt_q  <= '0;
                end
            end
            if ((state_q == ST_WAIT_DX) && dx_rsp_valid) begin
                phys_q <= dx_rsp_phys;
                cnt_q  <= dx_rsp_count;
            end
            if ((state_q == ST_WAIT_IX) && ix_rsp_valid) begin
                phys_q <= ix_rsp_phys;
                cnt_q  <= ix_rsp_count;
            end
        end
    end
endmodule

// File: rtl/dbg_addr_router_chk.sv
module dbg_addr_router_chk
    import dbg_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_phys,
    input logic [CNT_W-1:0]  rsp_count,
    input logic              dx_req_valid,
    input logic [OFF_W-1:0]  dx_req_offset,
    input logic              dx_rsp_valid,
    input logic              ix_req_valid,
    input logic [OFF_W-1:0]  ix_req_offset,
    input logic              ix_rsp_valid,
    input region_e           lat_region,
    input logic [CNT_W-1:0]  lat_cnt
);
    a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, rsp_valid, dx_req_valid, ix_req_valid}));

    a_r6_dx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_req_valid && !dx_rsp_valid) |=> (dx_req_valid && $stable(dx_req_offset)));

    a_r7_ix_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ix_req_valid && !ix_rsp_valid) |=> (ix_req_valid && $stable(ix_req_offset)));

    a_r5_clip_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && is_direct(lat_region)) |-> (rsp_count <= lat_cnt));

    a_r8_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (lat_region == RGN_NONE)) |-> ((rsp_count == '0) && (rsp_phys == '0)));
endmodule

bind dbg_addr_router dbg_addr_router_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_phys      (rsp_phys),
    .rsp_count     (rsp_count),
    .dx_req_valid  (dx_req_valid),
    .dx_req_offset (dx_req_offset),
    .dx_rsp_valid  (dx_rsp_valid),
    .ix_req_valid  (ix_req_valid),
    .ix_req_offset (ix_req_offset),
    .ix_rsp_valid  (ix_rsp_valid),
    .lat_region    (lat_region),
    .lat_cnt       (lat_cnt)
);

// File: tb/dbg_addr_router_tb_top.sv
`timescale 1ns/1ps
module dbg_addr_router_tb_top;
    localparam logic [31:0] UNIF = 32'h4000_0000;
    localparam logic [31:0] INSN = 32'h5000_0000;
    localparam logic [31:0] DATA = 32'h6000_0000;
    localparam logic [31:0] SEG  = 32'h0002_0000;
    localparam logic [31:0] DX_TAG = 32'hA000_0000;
    localparam logic [31:0] IX_TAG = 32'hB000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0, cfg_alt_num = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_count = '0;
    logic rsp_valid;
    logic [31:0] rsp_phys;
    logic [15:0] rsp_count;
    logic dx_req_valid, ix_req_valid;
    logic [23:0] dx_req_offset, ix_req_offset;
    logic [15:0] dx_req_count, ix_req_count;
    logic dx_rsp_valid = 1'b0, ix_rsp_valid = 1'b0;
    logic [31:0] dx_rsp_phys = '0, ix_rsp_phys = '0;
    logic [15:0] dx_rsp_count = '0, ix_rsp_count = '0;

    always #2.5 clk = ~clk;

    dbg_addr_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_alt_num(cfg_alt_num),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_count(req_count),
        .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_count(rsp_count),
        .dx_req_valid(dx_req_valid), .dx_req_offset(dx_req_offset), .dx_req_count(dx_req_count),
        .dx_rsp_valid(dx_rsp_valid), .dx_rsp_phys(dx_rsp_phys), .dx_rsp_count(dx_rsp_count),
        .ix_req_valid(ix_req_valid), .ix_req_offset(ix_req_offset), .ix_req_count(ix_req_count),
        .ix_rsp_valid(ix_rsp_valid), .ix_rsp_phys(ix_rsp_phys), .ix_rsp_count(ix_rsp_count)
    );

    // Translator models: answer after a few cycles with tagged results.
    logic [1:0] dx_wait = '0, ix_wait = '0;
    always @(posedge clk) begin
        dx_rsp_valid <= 1'b0;
        if (dx_req_valid && !dx_rsp_valid) begin
            if (dx_wait == 2'd2) begin
                dx_rsp_valid <= 1'b1;
                dx_wait      <= '0;
                dx_rsp_phys  <= DX_TAG | {8'h00, dx_req_offset};
                dx_rsp_count <= (dx_req_count == 16'd0) ? 16'd0 : dx_req_count - 16'd1;
            end else dx_wait <= dx_wait + 2'd1;
        end
    end
    always @(posedge clk) begin
        ix_rsp_valid <= 1'b0;
        if (ix_req_valid && !ix_rsp_valid) begin
            if (ix_wait == 2'd2) begin
                ix_rsp_valid <= 1'b1;
                ix_wait      <= '0;
                ix_rsp_phys  <= IX_TAG | {8'h00, ix_req_offset};
                ix_rsp_count <= ix_req_count >> 1;
            end else ix_wait <= ix_wait + 2'd1;
        end
    end

    typedef struct {
        logic [31:0] phys;
        logic [15:0] cnt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit alt_mode = 1'b0;
    bit finished = 1'b0;

    function automatic logic [15:0] clip(input logic [23:0] off, input logic [15:0] c);
        logic [31:0] room;
        room = SEG - ({8'h00, off} & (SEG - 32'd1));
        return ({16'h0, c} > room) ? room[15:0] : c;
    endfunction

    function automatic void model(input logic [31:0] a, input logic [15:0] c, input bit alt,
                                  output logic [31:0] p, output logic [15:0] n);
        logic [7:0]  code;
        logic [23:0] off;
        code = a[31:24];
        off  = a[23:0];
        if (alt) begin
            if      (code == 8'h00) code = 8'h10;
            else if (code == 8'h01) code = 8'h11;
            else if (code == 8'h10) code = 8'h02;
            else if (code == 8'h11) code = 8'h01;
            else if (code == 8'h12) code = 8'h00;
        end
        p = 32'h0;
        n = 16'h0;
        if (code == 8'h00)      begin p = UNIF + {8'h0, off}; n = clip(off, c); end
        else if (code == 8'h01) begin p = INSN + {8'h0, off}; n = clip(off, c); end
        else if (code == 8'h02) begin p = DATA + {8'h0, off}; n = clip(off, c); end
        else if (code == 8'h10) begin p = DX_TAG | {8'h0, off}; n = (c == 0) ? 16'd0 : c - 16'd1; end
        else if (code == 8'h11) begin p = IX_TAG | {8'h0, off}; n = c >> 1; end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: push the expectation, then present the request until taken.
    task automatic send(input logic [31:0] a, input logic [15:0] c, input string tag);
        exp_t e;
        model(a, c, alt_mode, e.phys, e.cnt);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_count = c;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_alt(input bit b);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_alt_num = b;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        alt_mode    = b;
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected response", rsp_phys, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_phys == e.phys, e.tag, "phys", rsp_phys, e.phys);
                check(rsp_count == e.cnt, e.tag, "count", {16'h0, rsp_count}, {16'h0, e.cnt});
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 32'h0, 32'h0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", {31'h0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check(!dx_req_valid && !ix_req_valid, "R1", "xlt requests",
              {30'h0, dx_req_valid, ix_req_valid}, 32'h0);
        send(32'h0000_0100, 16'd4, "R1");  drain();

        // R2 / R4 direct regions
        send(32'h0000_1234, 16'd8,  "R4"); drain();
        send(32'h0100_ABCD, 16'd4,  "R4"); drain();
        send(32'h0200_0010, 16'd2,  "R4"); drain();
        send(32'h00FF_FFF0, 16'd4,  "R2"); drain();
        send(32'h02C0_0000, 16'd1,  "R2"); drain();

        // R5 clipping
        send(32'h0001_FFF0, 16'h0040, "R5"); drain();
        send(32'h0103_FFFF, 16'd5,    "R5"); drain();
        send(32'h0202_0000, 16'hFFFF, "R5"); drain();
        send(32'h0201_FFF8, 16'd8,    "R5"); drain();

        // R6 / R7 translators
        send(32'h1000_0456, 16'd10, "R6"); drain();
        send(32'h1012_3456, 16'd0,  "R6"); drain();
        send(32'h1100_0789, 16'd10, "R7"); drain();

        // R8 refused codes
        send(32'h1200_0000, 16'd4, "R8"); drain();
        send(32'h0300_0000, 16'd4, "R8"); drain();
        send(32'hFF00_0040, 16'd4, "R8"); drain();

        // R9: busy window during a translator wait ignores req_valid
        send(32'h1000_0020, 16'd6, "R9");
        check(req_ready == 1'b0, "R9", "ready while busy", {31'h0, req_ready}, 32'h0);
        req_valid = 1'b1;
        req_addr  = 32'h0000_0500;
        req_count = 16'd3;
        @(negedge clk);
        check(req_ready == 1'b0, "R9", "ready while busy", {31'h0, req_ready}, 32'h0);
        req_valid = 1'b0;
        drain();

        // R3 alternate numbering
        set_alt(1'b1);
        send(32'h1200_0100, 16'd4, "R3"); drain();
        send(32'h1000_0200, 16'd4, "R3"); drain();
        send(32'h1100_0300, 16'd4, "R3"); drain();
        send(32'h0000_0400, 16'd7, "R3"); drain();
        send(32'h0100_0500, 16'd9, "R3"); drain();
        send(32'h0200_0600, 16'd4, "R3"); drain();
        send(32'h1300_0700, 16'd4, "R3"); drain();

        // R10 clearing the bit restores default decoding
        set_alt(1'b0);
        send(32'h1000_0800, 16'd3, "R10"); drain();
        send(32'h1200_0900, 16'd3, "R10"); drain();

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 32'h0);
        summary();
    end
endmodule